// File: doc/BRIEF.md
# Multi-Channel Event Counter Bank with Snapshot Shadows

This block holds four independent 32-bit event counters and one 32-bit elapsed-time timer. Each counter watches a pair of external inputs, A and B. Depending on its mode, the pair acts as separate up and down pulses, as a pulse with a direction line, or as a two-phase quadrature encoder. Every counter keeps a running value and compares it against a preset that the host has loaded. When an update lands on the preset, the counter raises its own sticky interrupt, with no help from the host.

The host never sees a live count. To read one, it requests a snapshot and names a channel: 0 to 3 for the counters, 4 for the timer. The running value of that channel is then copied into the channel's own shadow register, which the host can read freely. A snapshot can be triggered in two ways. In level mode, a copy is made on every cycle the request is held high. In edge mode, only a rising request makes a copy. Presets and modes are written through a small write-only register port. The timer advances once per tick of 0.1 ms, and the tick is derived from the system clock by a prescaler.

Top module: `cnt_bank`

## Requirements
- R1: After reset, every running value, every shadow register, every preset, every mode and every interrupt flag is zero.
- R2: In mode 0 (up/down), a rising edge on A adds one and a rising edge on B subtracts one. Rising edges on both inputs in the same cycle leave the value unchanged.
- R3: In mode 1 (pulse/direction), each rising edge on A changes the value by one. The step is upward when B is 0 and downward when B is 1. Edges on B alone do not count.
- R4: In mode 2 (quadrature), every change of the A/B pair counts once. The positions in the cycle 00→10→11→01→00 (written as A then B) count upward in that order and downward in reverse.
- R5: Running values wrap modulo 2^32 in both directions.
- R6: When a counting update makes the value equal to the preset, the channel's interrupt flag sets and stays set. A register write to address 2·NCH (8 by default) clears every flag whose data bit is one. A reset value that already equals the preset raises nothing.
- R7: The timer running value (channel 4) increases by exactly one every TICK_DIV clock cycles.
- R8: In level mode (snap_edge=0), every clock cycle with snap_en high copies the selected channel's running value into that channel's shadow register.
- R9: In edge mode (snap_edge=1), a copy happens only in the cycle where snap_en goes from 0 to 1. Holding snap_en high makes no further copies.
- R10: A snapshot request with snap_sel greater than 4 changes no shadow register.
- R11: A snapshot changes only the shadow register of the selected channel, and counters run independently of one another.
- R12: Writes to addresses 0 to 3 load the presets of channels 0 to 3. Writes to addresses 4 to 7 load the modes of channels 0 to 3 from data bits [1:0]. Mode 3 halts counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_a | input | NCH | A input of each counter channel |
| in_b | input | NCH | B input of each counter channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | clog2(2·NCH+1) | Register write address |
| wr_data | input | W | Register write data |
| snap_en | input | 1 | Snapshot request |
| snap_edge | input | 1 | 1 selects edge-triggered snapshot, 0 selects level-triggered |
| snap_sel | input | clog2(NCH+1) | Channel whose running value is copied |
| shadow_cv | output | (NCH+1)·W | Shadow registers; index NCH is the timer |
| irq | output | NCH | Sticky compare-match flag per counter |

## Verification
The bench pushes a channel down from zero and then back up, so that the count wraps and lands on the reset preset. A counter that saturates, or that matches without an update, shows up here in the shadow value or in the interrupt flag. It holds the snapshot request high across several counting events in both trigger modes. Edge mode treated as level would track the count, and level mode treated as edge would freeze it. It drives a simultaneous up/down edge, quadrature steps in both directions, a halted mode and an out-of-range select, and after each one it checks that untouched shadows and flags stay put. Two timer snapshots taken exactly five tick periods apart must differ by exactly five, which exposes an off-by-one in the prescaler.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic [1:0] {
    CM_UPDN = 2'd0,
    CM_PDIR = 2'd1,
    CM_QUAD = 2'd2,
    CM_HOLD = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;

  // Position of an A/B pair along the forward quadrature cycle.
  function automatic logic [1:0] quad_pos(input logic a, input logic b);
    logic [1:0] p;
    case ({a, b})
      2'b00:   p = 2'd0;
      2'b10:   p = 2'd1;
      2'b11:   p = 2'd2;
      default: p = 2'd3;
    endcase
    return p;
  endfunction

  // Counting decision for one channel, from synchronised current and
  // previous input samples.
  function automatic step_e decode_step(input cnt_mode_e m,
                                        input logic a_now, input logic a_old,
                                        input logic b_now, input logic b_old);
    logic  ra, rb;
    logic [1:0] d;
    step_e s;
    ra = a_now & ~a_old;
    rb = b_now & ~b_old;
    d  = quad_pos(a_now, b_now) - quad_pos(a_old, b_old);
    s  = STEP_NONE;
    case (m)
      CM_UPDN: begin
        if (ra && !rb)      s = STEP_UP;
        else if (rb && !ra) s = STEP_DN;
      end
      CM_PDIR: begin
        if (ra) s = b_now ? STEP_DN : STEP_UP;
      end
      CM_QUAD: begin
        if (d == 2'd1)      s = STEP_UP;
        else if (d == 2'd3) s = STEP_DN;
      end
      default: s = STEP_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cnt_sync_edge.sv
module cnt_sync_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_b,
  output logic [N-1:0] a_now,
  output logic [N-1:0] a_old,
  output logic [N-1:0] b_now,
  output logic [N-1:0] b_old
);
  logic [N-1:0] a_s1, b_s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_s1  <= '0;
      b_s1  <= '0;
      a_now <= '0;
      b_now <= '0;
      a_old <= '0;
      b_old <= '0;
    end else begin
      a_s1  <= in_a;
      b_s1  <= in_b;
      a_now <= a_s1;
      b_now <= b_s1;
      a_old <= a_now;
      b_old <= b_now;
    end
  end
endmodule

// File: rtl/cnt_channel.sv
module cnt_channel
  import cnt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cnt_mode_e    mode,
  input  logic         a_now,
  input  logic         a_old,
  input  logic         b_now,
  input  logic         b_old,
  input  logic         pv_load,
  input  logic [W-1:0] pv_in,
  input  logic         irq_clr,
  output logic [W-1:0] cv,
  output logic         irq,
  output logic         match_evt
);
  step_e        step;
  logic [W-1:0] cv_nxt;
  logic [W-1:0] pv_q;

  always_comb begin
    step = decode_step(mode, a_now, a_old, b_now, b_old);
    case (step)
      STEP_UP: cv_nxt = cv + 1'b1;
      STEP_DN: cv_nxt = cv - 1'b1;
      default: cv_nxt = cv;
    endcase
  end

  assign match_evt = (step != STEP_NONE) && (cv_nxt == pv_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv   <= '0;
      pv_q <= '0;
      irq  <= 1'b0;
    end else begin
      cv <= cv_nxt;
      if (pv_load) pv_q <= pv_in;
      if (match_evt)    irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/cnt_tick_timer.sv
module cnt_tick_timer #(
  parameter int W   = 32,
  parameter int DIV = 5000
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic         tick,
  output logic [W-1:0] tcv
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre;

  assign tick = (pre == PW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      tcv <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) tcv <= tcv + 1'b1;
    end
  end
endmodule

// File: rtl/cnt_bank.sv
module cnt_bank
  import cnt_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int W        = 32,
  parameter int TICK_DIV = 5000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NCH-1:0]               in_a,
  input  logic [NCH-1:0]               in_b,
  input  logic                         wr_en,
  input  logic [$clog2(2*NCH+1)-1:0]   wr_addr,
  input  logic [W-1:0]                 wr_data,
  input  logic                         snap_en,
  input  logic                         snap_edge,
  input  logic [$clog2(NCH+1)-1:0]     snap_sel,
  output logic [NCH:0][W-1:0]          shadow_cv,
  output logic [NCH-1:0]               irq
);
  localparam int AW = $clog2(2*NCH+1);
  localparam int SW = $clog2(NCH+1);

  logic [NCH-1:0]     a_now, a_old, b_now, b_old;
  logic [NCH-1:0]     pv_load, mode_load, irq_clr, match_vec;
  cnt_mode_e          mode_q [NCH];
  logic [NCH:0][W-1:0] cv_all;
  logic               tick;
  logic               en_q;
  logic               snap_fire;

  cnt_sync_edge #(.N(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b),
    .a_now(a_now), .a_old(a_old), .b_now(b_now), .b_old(b_old)
  );

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      pv_load[i]   = wr_en && (wr_addr == AW'(i));
      mode_load[i] = wr_en && (wr_addr == AW'(NCH + i));
      irq_clr[i]   = wr_en && (wr_addr == AW'(2 * NCH)) && wr_data[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) mode_q[i] <= CM_UPDN;
    end else begin
      for (int i = 0; i < NCH; i++)
        if (mode_load[i]) mode_q[i] <= cnt_mode_e'(wr_data[1:0]);
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cnt_channel #(.W(W)) u_ch (
      .clk(clk), .rst_n(rst_n), .mode(mode_q[g]),
      .a_now(a_now[g]), .a_old(a_old[g]), .b_now(b_now[g]), .b_old(b_old[g]),
      .pv_load(pv_load[g]), .pv_in(wr_data), .irq_clr(irq_clr[g]),
      .cv(cv_all[g]), .irq(irq[g]), .match_evt(match_vec[g])
    );
  end

  cnt_tick_timer #(.W(W), .DIV(TICK_DIV)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tcv(cv_all[NCH])
  );

  assign snap_fire = snap_edge ? (snap_en && !en_q) : snap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      shadow_cv <= '0;
    end else begin
      en_q <= snap_en;
      for (int j = 0; j <= NCH; j++)
        if (snap_fire && (snap_sel == SW'(j))) shadow_cv[j] <= cv_all[j];
    end
  end
endmodule

// File: rtl/cnt_bank_chk.sv
module cnt_bank_chk #(
  parameter int NCH = 4,
  parameter int W   = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NCH:0][W-1:0]        cv_all,
  input logic [NCH:0][W-1:0]        shadow,
  input logic                       snap_fire,
  input logic [$clog2(NCH+1)-1:0]   snap_sel,
  input logic                       tick,
  input logic [NCH-1:0]             irq,
  input logic [NCH-1:0]             irq_clr,
  input logic [NCH-1:0]             match_vec
);
  localparam int SW = $clog2(NCH+1);

  // R10
  bad_sel_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_fire && (snap_sel > SW'(NCH)) |=> $stable(shadow));

  // R7
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cv_all[NCH]));

  // R7
  timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cv_all[NCH] == W'($past(cv_all[NCH]) + 1'b1));

  for (genvar j = 0; j <= NCH; j++) begin : g_snap
    // R8
    snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_fire && (snap_sel == SW'(j)) |=> shadow[j] == $past(cv_all[j]));
    // R11
    snap_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(snap_fire && (snap_sel == SW'(j))) |=> $stable(shadow[j]));
  end

  for (genvar i = 0; i < NCH; i++) begin : g_irq
    // R6
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] && !irq_clr[i] |=> irq[i]);
    // R6
    match_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_vec[i] |=> irq[i]);
    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cv_all[i] == $past(cv_all[i])) ||
               (cv_all[i] == W'($past(cv_all[i]) + 1'b1)) ||
               (cv_all[i] == W'($past(cv_all[i]) - 1'b1)));
  end
endmodule

bind cnt_bank cnt_bank_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cv_all(cv_all), .shadow(shadow_cv),
  .snap_fire(snap_fire), .snap_sel(snap_sel), .tick(tick), .irq(irq),
  .irq_clr(irq_clr), .match_vec(match_vec)
);

// File: tb/cnt_bank_tb.sv
module cnt_bank_tb;
  localparam int NCH = 4;
  localparam int W   = 32;
  localparam int DIV = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    in_a = '0, in_b = '0;
  logic              wr_en = 1'b0;
  logic [3:0]        wr_addr = '0;
  logic [W-1:0]      wr_data = '0;
  logic              snap_en = 1'b0, snap_edge = 1'b0;
  logic [2:0]        snap_sel = '0;
  logic [NCH:0][W-1:0] shadow_cv;
  logic [NCH-1:0]    irq;

  int total = 0;
  int fails = 0;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sbq[$];
  event  chk_ev;

  always #5 clk = ~clk;

  cnt_bank #(.NCH(NCH), .W(W), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .snap_en(snap_en), .snap_edge(snap_edge), .snap_sel(snap_sel),
    .shadow_cv(shadow_cv), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected shadow values as snapshots complete.
  initial begin
    forever begin
      @(chk_ev);
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        check(shadow_cv[it.sel] == it.exp, it.req, shadow_cv[it.sel], it.exp);
      end
    end
  end

  task automatic snap(input int sel, input logic [31:0] exp, input string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    sbq.push_back(it);
    @(negedge clk); snap_en = 1'b1; snap_sel = 3'(sel);
    @(negedge clk); snap_en = 1'b0;
    -> chk_ev;
    @(negedge clk);
  endtask

  task automatic host_wr(input int addr, input logic [31:0] data);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'(addr); wr_data = data;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input int ch, input bit on_a, input bit on_b);
    @(negedge clk);
    if (on_a) in_a[ch] = 1'b1;
    if (on_b) in_b[ch] = 1'b1;
    repeat (4) @(negedge clk);
    if (on_a) in_a[ch] = 1'b0;
    if (on_b) in_b[ch] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic qstep(input int ch, input bit a, input bit b);
    @(negedge clk); in_a[ch] = a; in_b[ch] = b;
    repeat (4) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [NCH:0][W-1:0] saved;
    logic [31:0] t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(shadow_cv == '0, "R1 shadow reset", shadow_cv[0], 0);
    check(irq == '0, "R1 irq reset", irq, 0);
    snap(0, 32'd0, "R1 cv reset");

    // R2 up/down mode on channel 0
    pulse(0, 1, 0); pulse(0, 1, 0); pulse(0, 1, 0); pulse(0, 0, 1);
    snap(0, 32'd2, "R2 up/down count");
    pulse(0, 1, 1);
    snap(0, 32'd2, "R2 simultaneous edges");

    // R5 wrap on channel 3, R6 match at reset preset 0
    pulse(3, 0, 1);
    snap(3, 32'hFFFF_FFFF, "R5 wrap down");
    check(irq == 4'b0000, "R6 no irq before match", irq, 0);
    pulse(3, 1, 0);
    snap(3, 32'd0, "R5 wrap up");
    check(irq == 4'b1000, "R6 irq on match", irq, 4'b1000);
    host_wr(8, 32'h8);
    @(negedge clk);
    check(irq == 4'b0000, "R6 w1c clear", irq, 0);

    // R3 pulse/direction on channel 1 (R12 mode address)
    host_wr(5, 32'd1);
    pulse(1, 1, 0); pulse(1, 1, 0); pulse(1, 1, 0);
    @(negedge clk); in_b[1] = 1'b1; repeat (4) @(negedge clk);
    pulse(1, 1, 0);
    snap(1, 32'd2, "R3 pulse/direction");
    in_b[1] = 1'b0; repeat (4) @(negedge clk);
    snap(1, 32'd2, "R3 direction edge ignored");

    // R4 quadrature on channel 2
    host_wr(6, 32'd2);
    qstep(2, 1, 0); qstep(2, 1, 1); qstep(2, 0, 1); qstep(2, 0, 0);
    snap(2, 32'd4, "R4 quad forward");
    qstep(2, 0, 1); qstep(2, 1, 1);
    snap(2, 32'd2, "R4 quad reverse");

    // R12 hold mode on channel 3
    host_wr(7, 32'd3);
    pulse(3, 1, 0); pulse(3, 0, 1);
    snap(3, 32'd0, "R12 hold mode");

    // R6 compare with preset 4 on channel 0 (R12 preset address)
    host_wr(0, 32'd4);
    pulse(0, 1, 0);
    check(irq == 4'b0000, "R6 below preset", irq, 0);
    pulse(0, 1, 0);
    check(irq == 4'b0001, "R6 match preset", irq, 4'b0001);
    pulse(0, 1, 0);
    check(irq == 4'b0001, "R6 sticky", irq, 4'b0001);
    host_wr(8, 32'h1);
    @(negedge clk);
    check(irq == 4'b0000, "R6 clear", irq, 0);

    // R8 level mode: held request tracks the count (cv 5 -> 7)
    snap_edge = 1'b0;
    @(negedge clk); snap_sel = 3'd0; snap_en = 1'b1;
    pulse(0, 1, 0); pulse(0, 1, 0);
    repeat (2) @(negedge clk);
    check(shadow_cv[0] == 32'd7, "R8 level tracks", shadow_cv[0], 7);
    snap_en = 1'b0;
    @(negedge clk);

    // R9 edge mode: held request copies once (7), count goes on to 9
    snap_edge = 1'b1;
    @(negedge clk); snap_en = 1'b1;
    pulse(0, 1, 0); pulse(0, 1, 0);
    repeat (2) @(negedge clk);
    check(shadow_cv[0] == 32'd7, "R9 edge single copy", shadow_cv[0], 7);
    snap_en = 1'b0;
    @(negedge clk);
    snap(0, 32'd9, "R9 new rising edge");
    snap_edge = 1'b0;

    // R10 out-of-range select
    pulse(0, 1, 0);
    saved = shadow_cv;
    @(negedge clk); snap_en = 1'b1; snap_sel = 3'd5;
    @(negedge clk); snap_sel = 3'd7;
    @(negedge clk); snap_en = 1'b0;
    @(negedge clk);
    check(shadow_cv == saved, "R10 select >4 ignored", shadow_cv[0], saved[0]);

    // R11 only selected shadow changes
    saved = shadow_cv;
    snap(0, 32'd10, "R11 selected shadow");
    check(shadow_cv[1] == saved[1] && shadow_cv[2] == saved[2] &&
          shadow_cv[3] == saved[3] && shadow_cv[4] == saved[4],
          "R11 other shadows", shadow_cv[2], saved[2]);

    // R7 timer: two snapshots exactly 5*DIV cycles apart
    @(negedge clk); snap_en = 1'b1; snap_sel = 3'd4;
    @(negedge clk); snap_en = 1'b0;
    t1 = shadow_cv[4];
    repeat (5 * DIV - 1) @(negedge clk);
    snap_en = 1'b1;
    @(negedge clk); snap_en = 1'b0;
    t2 = shadow_cv[4];
    check(t2 - t1 == 32'd5, "R7 timer rate", t2 - t1, 5);
    check(t1 != 32'd0, "R7 timer running", t1, 1);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule